// File: doc/BRIEF.md
# Floating-point status and compare-result unit

This block holds the floating-point status word of a processor core. Arithmetic units report the outcome of each operation as five exception flags. The unit loads those flags as the current exceptions and compares them with the trap-enable field. If any flag is enabled, it marks the trap type as an IEEE exception and pulses a trap request. Otherwise it merges the flags into the accrued field.

Compare units report a result that is equal, less, greater or unordered. The unit writes the matching 2-bit condition code into one of four selectable condition fields. An unordered result goes down a separate invalid-operation path. That path traps when the invalid enable is set or the compare is the signalling kind, and only accrues the invalid flag otherwise.

The rounding-direction field is decoded into a rounding-mode output for the datapath. Software can load the whole status word through a write port.

Top module: `fpsu_status_unit`

## Requirements
- R1: After reset, the status word is all zero, the trap request is low and the rounding mode is nearest (2'b00).
- R2: A flag strobe replaces the current-exception field [4:0] with the flag input on the next cycle. Bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0.
- R3: If a flag strobe has any flag that is also set in the trap-enable field [27:23] (same bit order), the trap-type field [16:14] becomes 3'b001 and trap_o is high for the cycle after the strobe. The accrued field is unchanged.
- R4: If a flag strobe has no enabled flag, the flags are ORed into the accrued field [9:5], trap_o stays low and the trap-type field is unchanged.
- R5: A compare clears the selected condition field, then writes less=01, greater=10, unordered=11 or equal=00 into it. All other condition fields are unchanged. cmp_res_i is one-hot {unordered, greater, less, equal} with priority in that order; no bit set means equal.
- R6: fcc_sel_i picks the condition field: 0 selects bits [11:10], 1 selects [33:32], 2 selects [35:34] and 3 selects [37:36].
- R7: An unordered compare with the invalid enable (bit 27) set, or with cmp_sig_i high, sets current-exception bit 4 (other current bits kept), sets the trap type to 3'b001 and pulses trap_o.
- R8: An unordered compare with the invalid enable clear and cmp_sig_i low sets accrued bit 9, leaves trap_o low and leaves the current-exception field unchanged.
- R9: rnd_mode_o decodes rounding field [31:30]. 00 gives nearest-even (00), 01 gives toward zero (01), 10 gives toward +infinity (11) and 11 gives toward -infinity (10).
- R10: A write loads wr_data_i into the whole status word on the next cycle with trap_o low. A write takes priority over a compare or flag strobe in the same cycle, which is then ignored.
- R11: In a cycle with no write, compare or flag strobe, the status word holds and trap_o is low on the next cycle.
- R12: A compare and a flag strobe in the same cycle perform the compare only; the flags are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_vld_i | input | 1 | One-cycle strobe: exception flags valid |
| flag_i | input | 5 | Exception flags of one operation |
| cmp_vld_i | input | 1 | One-cycle strobe: compare result valid |
| cmp_res_i | input | 4 | One-hot compare result {unordered, greater, less, equal} |
| fcc_sel_i | input | 2 | Target condition field |
| cmp_sig_i | input | 1 | Compare is the signalling kind |
| wr_en_i | input | 1 | Software load of the status word |
| wr_data_i | input | 64 | Value to load |
| fsr_o | output | 64 | Status word |
| trap_o | output | 1 | Floating-point trap request pulse |
| rnd_mode_o | output | 2 | Decoded rounding mode |

## Verification
The bench uses the default parameters: a 64-bit status word and four condition fields. With these values, the three condition fields above bit 31 can be reached, so the bench can show that a compare into one field leaves the other three fields intact. The 5-bit flag width lines the enable field up with the current field. Trapping and accruing flag strobes, the quiet, signalling and enable-driven unordered paths, and the priority between same-cycle operations can then all be driven from the ports.

// File: rtl/fpsu_pkg.sv
package fpsu_pkg;
  localparam int FSR_W    = 64;
  localparam int FLAG_W   = 5;
  localparam int FCC_W    = 2;
  localparam int NUM_FCC  = 4;
  localparam int SEL_W    = $clog2(NUM_FCC);
  localparam int RES_W    = 4;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = CEXC_LSB + FLAG_W;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam int RD_LSB   = 30;
  localparam int FCC0_LSB = 10;
  localparam int FCCX_LSB = 32;
  localparam int FLG_NV   = 4;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_NEG  = 2'b10,
    RND_POS  = 2'b11
  } rnd_mode_e;

  typedef enum logic [FCC_W-1:0] {
    FCC_EQ = 2'b00,
    FCC_LT = 2'b01,
    FCC_GT = 2'b10,
    FCC_UN = 2'b11
  } fcc_e;

  // field 0 sits low, the others are packed above bit 31
  function automatic int fcc_lsb(int idx);
    return (idx == 0) ? FCC0_LSB : FCCX_LSB + FCC_W * (idx - 1);
  endfunction
endpackage

// File: rtl/fpsu_flag_unit.sv
module fpsu_flag_unit
  import fpsu_pkg::*;
(
  input  logic [FSR_W-1:0]  fsr_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic              trap_o
);
  logic [FLAG_W-1:0] hit;

  assign hit = flag_i & fsr_i[TEM_LSB +: FLAG_W];

  always_comb begin
    fsr_o  = fsr_i;
    trap_o = 1'b0;
    fsr_o[CEXC_LSB +: FLAG_W] = flag_i;
    if (|hit) begin
      fsr_o[FTT_LSB +: FTT_W] = FTT_IEEE;
      trap_o = 1'b1;
    end else begin
      fsr_o[AEXC_LSB +: FLAG_W] = fsr_i[AEXC_LSB +: FLAG_W] | flag_i;
    end
  end
endmodule

// File: rtl/fpsu_cmp_unit.sv
module fpsu_cmp_unit
  import fpsu_pkg::*;
(
  input  logic [FSR_W-1:0] fsr_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sig_i,
  output logic [FSR_W-1:0] fsr_o,
  output logic             trap_o
);
  fcc_e             code;
  logic [FSR_W-1:0] fld_mask [NUM_FCC];
  logic [FSR_W-1:0] fld_ins  [NUM_FCC];

  always_comb begin
    if (res_i[3])      code = FCC_UN;
    else if (res_i[2]) code = FCC_GT;
    else if (res_i[1]) code = FCC_LT;
    else               code = FCC_EQ;
  end

  for (genvar g = 0; g < NUM_FCC; g++) begin : g_fld
    localparam int LSB = fcc_lsb(g);
    assign fld_mask[g] = {{(FSR_W-FCC_W){1'b0}}, {FCC_W{1'b1}}} << LSB;
    assign fld_ins[g]  = {{(FSR_W-FCC_W){1'b0}}, code} << LSB;
  end

  always_comb begin
    fsr_o  = (fsr_i & ~fld_mask[sel_i]) | fld_ins[sel_i];
    trap_o = 1'b0;
    if (code == FCC_UN) begin
      if (fsr_i[TEM_LSB + FLG_NV] || sig_i) begin
        fsr_o[CEXC_LSB + FLG_NV] = 1'b1;
        fsr_o[FTT_LSB +: FTT_W]  = FTT_IEEE;
        trap_o = 1'b1;
      end else begin
        fsr_o[AEXC_LSB + FLG_NV] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpsu_rnd_dec.sv
module fpsu_rnd_dec
  import fpsu_pkg::*;
(
  input  logic [1:0] rd_i,
  output rnd_mode_e  mode_o
);
  always_comb begin
    unique case (rd_i)
      2'b00:   mode_o = RND_NEAR;
      2'b01:   mode_o = RND_ZERO;
      2'b10:   mode_o = RND_POS;
      default: mode_o = RND_NEG;
    endcase
  end
endmodule

// File: rtl/fpsu_status_unit.sv
module fpsu_status_unit
  import fpsu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_vld_i,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic              cmp_vld_i,
  input  logic [RES_W-1:0]  cmp_res_i,
  input  logic [SEL_W-1:0]  fcc_sel_i,
  input  logic              cmp_sig_i,
  input  logic              wr_en_i,
  input  logic [FSR_W-1:0]  wr_data_i,
  output logic [FSR_W-1:0]  fsr_o,
  output logic              trap_o,
  output logic [1:0]        rnd_mode_o
);
  logic [FSR_W-1:0] fsr_q, flag_nxt, cmp_nxt;
  logic             trap_q, flag_trap, cmp_trap;
  rnd_mode_e        mode;

  fpsu_flag_unit i_flag (
    .fsr_i (fsr_q),
    .flag_i(flag_i),
    .fsr_o (flag_nxt),
    .trap_o(flag_trap)
  );

  fpsu_cmp_unit i_cmp (
    .fsr_i (fsr_q),
    .res_i (cmp_res_i),
    .sel_i (fcc_sel_i),
    .sig_i (cmp_sig_i),
    .fsr_o (cmp_nxt),
    .trap_o(cmp_trap)
  );

  fpsu_rnd_dec i_rnd (
    .rd_i  (fsr_q[RD_LSB +: 2]),
    .mode_o(mode)
  );

  // priority: software write, then compare, then flag strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q  <= '0;
      trap_q <= 1'b0;
    end else if (wr_en_i) begin
      fsr_q  <= wr_data_i;
      trap_q <= 1'b0;
    end else if (cmp_vld_i) begin
      fsr_q  <= cmp_nxt;
      trap_q <= cmp_trap;
    end else if (flag_vld_i) begin
      fsr_q  <= flag_nxt;
      trap_q <= flag_trap;
    end else begin
      trap_q <= 1'b0;
    end
  end

  assign fsr_o      = fsr_q;
  assign trap_o     = trap_q;
  assign rnd_mode_o = mode;
endmodule

// File: rtl/fpsu_status_chk.sv
module fpsu_status_chk
  import fpsu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flag_vld_i,
  input logic [FLAG_W-1:0] flag_i,
  input logic              cmp_vld_i,
  input logic [RES_W-1:0]  cmp_res_i,
  input logic [SEL_W-1:0]  fcc_sel_i,
  input logic              cmp_sig_i,
  input logic              wr_en_i,
  input logic [FSR_W-1:0]  wr_data_i,
  input logic [FSR_W-1:0]  fsr_o,
  input logic              trap_o,
  input logic [1:0]        rnd_mode_o
);
  logic seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;
  end

  function automatic logic [1:0] fld_of(logic [FSR_W-1:0] f, logic [SEL_W-1:0] s);
    case (s)
      2'd0:    return f[11:10];
      2'd1:    return f[33:32];
      2'd2:    return f[35:34];
      default: return f[37:36];
    endcase
  endfunction

  function automatic logic [1:0] code_of(logic [RES_W-1:0] r);
    if (r[3]) return 2'b11;
    if (r[2]) return 2'b10;
    if (r[1]) return 2'b01;
    return 2'b00;
  endfunction

  AST_TRAP_SETS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> fsr_o[16:14] == 3'b001); // R3

  AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(wr_en_i) |-> fsr_o == $past(wr_data_i) && !trap_o); // R10

  AST_FLAG_REPLACES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(flag_vld_i && !cmp_vld_i && !wr_en_i) |-> fsr_o[4:0] == $past(flag_i)); // R2

  AST_FLAG_ACCRUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(flag_vld_i && !cmp_vld_i && !wr_en_i) && !trap_o
      |-> fsr_o[9:5] == ($past(fsr_o[9:5]) | $past(flag_i))); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(!flag_vld_i && !cmp_vld_i && !wr_en_i) |-> $stable(fsr_o) && !trap_o); // R11

  AST_FCC_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(cmp_vld_i && !wr_en_i)
      |-> fld_of(fsr_o, $past(fcc_sel_i)) == code_of($past(cmp_res_i))); // R5

  AST_UN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(cmp_vld_i && !wr_en_i && cmp_res_i[3] && !cmp_sig_i && !fsr_o[27])
      |-> fsr_o[9] && !trap_o); // R8

  AST_UN_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && $past(cmp_vld_i && !wr_en_i && cmp_res_i[3] && (cmp_sig_i || fsr_o[27]))
      |-> fsr_o[4] && trap_o); // R7
endmodule

bind fpsu_status_unit fpsu_status_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .flag_vld_i(flag_vld_i),
  .flag_i    (flag_i),
  .cmp_vld_i (cmp_vld_i),
  .cmp_res_i (cmp_res_i),
  .fcc_sel_i (fcc_sel_i),
  .cmp_sig_i (cmp_sig_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .fsr_o     (fsr_o),
  .trap_o    (trap_o),
  .rnd_mode_o(rnd_mode_o)
);

// File: tb/test_fpsu_status_unit.sv
module test_fpsu_status_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flag_vld_i = 1'b0;
  logic [4:0]  flag_i = '0;
  logic        cmp_vld_i = 1'b0;
  logic [3:0]  cmp_res_i = '0;
  logic [1:0]  fcc_sel_i = '0;
  logic        cmp_sig_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [63:0] fsr_o;
  logic        trap_o;
  logic [1:0]  rnd_mode_o;

  always #10 clk_i = ~clk_i;

  fpsu_status_unit i_fpsu_status_unit (
    .clk_i, .rst_ni, .flag_vld_i, .flag_i, .cmp_vld_i, .cmp_res_i,
    .fcc_sel_i, .cmp_sig_i, .wr_en_i, .wr_data_i, .fsr_o, .trap_o, .rnd_mode_o
  );

  typedef struct {
    logic [63:0] fsr;
    logic        trap;
    logic [1:0]  rnd;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] m = '0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  function automatic logic [1:0] rnd_of(logic [63:0] f);
    case (f[31:30])
      2'b00:   return 2'b00;
      2'b01:   return 2'b01;
      2'b10:   return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit wr, logic [63:0] wd, bit fv, logic [4:0] fl, bit cv,
                    logic [3:0] res, logic [1:0] sel, bit sig, string tag);
    bit   t = 1'b0;
    int   off;
    logic [1:0] code;
    exp_t e;
    if (wr) begin
      m = wd;
    end else if (cv) begin
      off  = (sel == 0) ? 10 : 30 + 2 * int'(sel);
      code = res[3] ? 2'b11 : res[2] ? 2'b10 : res[1] ? 2'b01 : 2'b00;
      m[off +: 2] = code;
      if (code == 2'b11) begin
        if (m[27] || sig) begin
          m[4] = 1'b1;
          m[16:14] = 3'b001;
          t = 1'b1;
        end else begin
          m[9] = 1'b1;
        end
      end
    end else if (fv) begin
      m[4:0] = fl;
      if ((fl & m[27:23]) != 0) begin
        m[16:14] = 3'b001;
        t = 1'b1;
      end else begin
        m[9:5] = m[9:5] | fl;
      end
    end
    @(negedge clk_i);
    wr_en_i = wr; wr_data_i = wd; flag_vld_i = fv; flag_i = fl;
    cmp_vld_i = cv; cmp_res_i = res; fcc_sel_i = sel; cmp_sig_i = sig;
    e.fsr = m; e.trap = t; e.rnd = rnd_of(m); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    op(0, '0, 0, '0, 0, '0, '0, 0, tag);
  endtask

  // monitor: compares each expected item against the outputs after its edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk_i);
      #5;
      if (q.size() != 0) begin
        e = q.pop_front();
        chk({e.tag, " fsr"}, fsr_o, e.fsr);
        chk({e.tag, " trap"}, {63'd0, trap_o}, {63'd0, e.trap});
        chk({e.tag, " rnd"}, {62'd0, rnd_mode_o}, {62'd0, e.rnd});
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset fsr", fsr_o, '0);
    chk("R1 reset trap", {63'd0, trap_o}, '0);
    chk("R1 reset rnd", {62'd0, rnd_mode_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release fsr", fsr_o, '0);

    op(0, '0, 1, 5'b00011, 0, '0, '0, 0, "R2 R4 accrue dz nx");
    op(0, '0, 1, 5'b10000, 0, '0, '0, 0, "R2 replace nv");
    op(1, (64'd1 << 26) | (64'd1 << 30), 0, '0, 0, '0, '0, 0, "R10 R9 write of-enable rd01");
    op(0, '0, 1, 5'b01001, 0, '0, '0, 0, "R3 trap on overflow");
    idle("R11 trap drops");
    op(0, '0, 1, 5'b00001, 0, '0, '0, 0, "R4 unenabled nx accrues");
    op(0, '0, 0, '0, 1, 4'b0010, 2'd0, 0, "R5 R6 less fcc0");
    op(0, '0, 0, '0, 1, 4'b0100, 2'd1, 0, "R5 R6 greater fcc1");
    op(0, '0, 0, '0, 1, 4'b1000, 2'd2, 0, "R8 R6 quiet unordered fcc2");
    op(0, '0, 0, '0, 1, 4'b1000, 2'd3, 1, "R7 R6 signalling unordered fcc3");
    op(0, '0, 0, '0, 1, 4'b0001, 2'd2, 0, "R5 equal clears fcc2");
    op(1, (64'd1 << 27) | (64'd2 << 30), 0, '0, 0, '0, '0, 0, "R10 R9 write nv-enable rd10");
    op(0, '0, 0, '0, 1, 4'b1000, 2'd0, 0, "R7 enabled unordered fcc0");
    op(1, 64'h0000_0000_0000_0c00, 1, 5'b11111, 1, 4'b0010, 2'd1, 0, "R10 write wins");
    op(0, '0, 1, 5'b00110, 1, 4'b0100, 2'd0, 0, "R12 compare beats flags");
    op(1, (64'd3 << 30) | (64'd3 << 36), 0, '0, 0, '0, '0, 0, "R9 rd11");
    op(0, '0, 0, '0, 1, 4'b0000, 2'd3, 0, "R5 no bit means equal fcc3");
    idle("R11 hold");
    idle("R11 hold");
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule